// File: doc/BRIEF.md
# Two-Stage Fetch Front End with Branch Kill

This block is the control-flow front end of a two-stage 32-bit RISC-V pipeline. The first stage holds the program counter and presents it to instruction memory. A stage register then captures the fetched word together with the address it came from. The second stage decodes, executes, accesses memory and writes back, all in one cycle. The block decodes only what it needs to steer fetch: conditional branches, `jal` and `jalr`.

For branches it compares the two register operands with its own comparator, which reports equality and less-than. The less-than sense is signed or unsigned depending on the branch kind. It chooses the next fetch address from the sequential address, a PC-relative target or a register-relative target. When the instruction in stage two redirects fetch, the word that was fetched in the same cycle is on the wrong path. That word is replaced in the stage register by the no-op `addi x0,x0,0`, which costs one bubble per redirect.

The register operands come from a register file outside the block, indexed by the stage-two instruction. The block returns the link value for jumps.

Top module: `fetch2_frontend`

## Requirements
- R1: While reset is asserted and until the first clock edge after its release, the fetch address is 0, the stage-two instruction is 0x00000013, the stage-two PC is 0, and no redirect is signalled.
- R2: When stage two does not redirect, each clock edge moves the fetch address forward by 4. The same edge loads the fetched word and its fetch address into the stage register.
- R3: When stage two redirects, the next edge loads 0x00000013 into the stage register instead of the fetched word. Its PC field still takes the fetch address, so a redirect is never followed directly by another.
- R4: A branch (opcode bits [6:0] = 0x63) is taken according to funct3 (bits [14:12]). The codes are 0 equal, 1 not equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than and 7 unsigned greater-or-equal. Codes 2 and 3 are never taken. A branch redirects only when it is taken.
- R5: A taken branch sends fetch to the stage-two PC plus the sign-extended B-format offset: bit 31, bit 7, bits 30:25 and bits 11:8, with a zero in bit 0.
- R6: `jal` (opcode 0x6f) always redirects fetch to the stage-two PC plus the sign-extended J-format offset: bit 31, bits 19:12, bit 20 and bits 30:21, with a zero in bit 0.
- R7: `jalr` (opcode 0x67) always redirects fetch to rs1 plus the sign-extended immediate in bits 31:20, with bit 0 of the sum cleared.
- R8: The link output always equals the stage-two PC plus 4.
- R9: Any opcode other than 0x63, 0x6f and 0x67 never redirects fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Byte address of the word being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| rs1_val | input | 32 | First register operand of the stage-two instruction |
| rs2_val | input | 32 | Second register operand of the stage-two instruction |
| ex_inst | output | 32 | Instruction held in stage two |
| ex_pc | output | 32 | Address of the instruction held in stage two |
| link_val | output | 32 | Return address for jumps (stage-two PC plus 4) |
| redirect | output | 1 | Stage two is changing the fetch path this cycle |

## Verification
In every redirect cycle, the resolution of a control transfer in stage two coincides with the fetch of the next sequential word. That word may itself be a jump or a taken branch. The random program is dense in branches and jumps, and equal operands are drawn often, so this overlap occurs many times. One directed case places a `jal` directly behind a taken `beq`. The bench judges each cycle against a reference state machine. It requires the wrong-path word to appear in stage two as 0x00000013 with its fetch address, and it requires fetch to follow only the older instruction's target.

// File: rtl/fetch2_frontend.sv
module fetch2_frontend #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter logic [31:0] NOP_WORD = 32'h0000_0013
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  output logic [31:0] ex_inst,
  output logic [31:0] ex_pc,
  output logic [31:0] link_val,
  output logic        redirect
);

  localparam logic [6:0] OP_BRANCH = 7'h63;
  localparam logic [6:0] OP_JAL    = 7'h6f;
  localparam logic [6:0] OP_JALR   = 7'h67;

  logic [31:0] pc_q, inst_q, epc_q;
  logic [31:0] imm_i, imm_b, imm_j, target, next_pc;
  logic        is_br, is_jal, is_jalr, eq, lt, taken;
  logic [2:0]  f3;

  assign f3      = inst_q[14:12];
  assign is_br   = inst_q[6:0] == OP_BRANCH;
  assign is_jal  = inst_q[6:0] == OP_JAL;
  assign is_jalr = inst_q[6:0] == OP_JALR;

  assign imm_i = {{20{inst_q[31]}}, inst_q[31:20]};
  assign imm_b = {{19{inst_q[31]}}, inst_q[31], inst_q[7], inst_q[30:25], inst_q[11:8], 1'b0};
  assign imm_j = {{11{inst_q[31]}}, inst_q[31], inst_q[19:12], inst_q[20], inst_q[30:21], 1'b0};

  // comparator: f3[1] selects unsigned ordering
  assign eq = rs1_val == rs2_val;
  assign lt = f3[1] ? (rs1_val < rs2_val) : ($signed(rs1_val) < $signed(rs2_val));

  always_comb begin
    case (f3)
      3'd0:    taken = eq;
      3'd1:    taken = !eq;
      3'd4,
      3'd6:    taken = lt;
      3'd5,
      3'd7:    taken = !lt;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    if (is_jalr)     target = (rs1_val + imm_i) & ~32'd1;
    else if (is_jal) target = epc_q + imm_j;
    else             target = epc_q + imm_b;
  end

  assign redirect = is_jal || is_jalr || (is_br && taken);
  assign next_pc  = redirect ? target : pc_q + 32'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      inst_q <= NOP_WORD;
      epc_q  <= RESET_PC;
    end else begin
      pc_q   <= next_pc;
      inst_q <= redirect ? NOP_WORD : imem_data;
      epc_q  <= pc_q;
    end
  end

  assign imem_addr = pc_q;
  assign ex_inst   = inst_q;
  assign ex_pc     = epc_q;
  assign link_val  = epc_q + 32'd4;

  assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !redirect) |=> imem_addr == $past(imem_addr) + 32'd4);

  assert_pc_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ex_pc == $past(imem_addr));

  assert_kill_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && redirect) |=> ex_inst == NOP_WORD);

  assert_single_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && redirect) |=> !redirect);

  assert_jal_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && ex_inst[6:0] == OP_JAL) |=> imem_addr == $past(ex_pc + imm_j));

  assert_jalr_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && ex_inst[6:0] == OP_JALR) |=> imem_addr[0] == 1'b0);

  assert_unused_f3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_inst[6:0] == OP_BRANCH && ex_inst[14:13] == 2'b01) |-> !redirect);

endmodule

// File: tb/test_fetch2_frontend.sv
module test_fetch2_frontend;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, rs1_val, rs2_val, ex_inst, ex_pc, link_val;
  logic        redirect;
  logic [31:0] mem [64];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_pc, m_inst, m_epc;

  always #2 clk = ~clk;

  assign imem_data = mem[imem_addr[7:2]];

  fetch2_frontend i_fetch2_frontend (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .ex_inst(ex_inst), .ex_pc(ex_pc),
    .link_val(link_val), .redirect(redirect)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_b(input logic [2:0] f3, input logic [12:0] off);
    return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'h63};
  endfunction

  function automatic logic [31:0] enc_j(input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'h6f};
  endfunction

  function automatic logic [31:0] enc_jr(input logic [11:0] imm);
    return {imm, 5'd3, 3'd0, 5'd1, 7'h67};
  endfunction

  // reference resolution: {redirect, target}
  function automatic logic [32:0] resolve(input logic [31:0] i, input logic [31:0] epc,
                                          input logic [31:0] a, input logic [31:0] b);
    logic t;
    logic [31:0] ob, oj, oi;
    ob = {{19{i[31]}}, i[31], i[7], i[30:25], i[11:8], 1'b0};
    oj = {{11{i[31]}}, i[31], i[19:12], i[20], i[30:21], 1'b0};
    oi = {{20{i[31]}}, i[31:20]};
    case (i[14:12])
      3'd0: t = (a == b);
      3'd1: t = (a != b);
      3'd4: t = ($signed(a) < $signed(b));
      3'd5: t = ($signed(a) >= $signed(b));
      3'd6: t = (a < b);
      3'd7: t = (a >= b);
      default: t = 1'b0;
    endcase
    if (i[6:0] == 7'h6f) return {1'b1, epc + oj};
    if (i[6:0] == 7'h67) return {1'b1, (a + oi) & 32'hFFFF_FFFE};
    if (i[6:0] == 7'h63 && t) return {1'b1, epc + ob};
    return {1'b0, 32'h0};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    rs1_val = 0; rs2_val = 0;
    m_pc = 0; m_inst = NOP; m_epc = 0;
    @(negedge clk);
    chk(imem_addr == 0, "R1 fetch addr", imem_addr, 0);
    chk(ex_inst == NOP, "R1 stage inst", ex_inst, NOP);
    chk(ex_pc == 0, "R1 stage pc", ex_pc, 0);
    chk(redirect == 1'b0, "R1 redirect", {31'd0, redirect}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle at a negedge: drive operands, compare with model, advance model
  task automatic step(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] r;
    rs1_val = a; rs2_val = b;
    #1;
    r = resolve(m_inst, m_epc, a, b);
    chk(imem_addr == m_pc, "R2 fetch address", imem_addr, m_pc);
    chk(ex_inst == m_inst, "R3 stage-two instruction", ex_inst, m_inst);
    chk(ex_pc == m_epc, "R2 stage-two pc", ex_pc, m_epc);
    chk(link_val == m_epc + 4, "R8 link value", link_val, m_epc + 4);
    chk(redirect == r[32], "R4 redirect decision", {31'd0, redirect}, {31'd0, r[32]});
    m_epc = m_pc;
    if (r[32]) begin
      m_inst = NOP;
      m_pc = r[31:0];
    end else begin
      m_inst = mem[m_pc[7:2]];
      m_pc = m_pc + 4;
    end
    @(negedge clk);
  endtask

  task automatic fill_nop();
    for (int k = 0; k < 64; k++) mem[k] = NOP;
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom % 6)
      0: return 32'hFFFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'h0000_0001;
      3: return 32'h7FFF_FFFF;
      default: return $urandom % 8;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd2024));

    // taken beq with a jal in the wrong-path slot (R3, R5)
    fill_nop();
    mem[0] = enc_b(3'd0, 13'd16);
    mem[1] = enc_j(21'd8);
    do_reset();
    step(0, 0);
    step(5, 5);
    chk(ex_inst == NOP, "R3 killed jal", ex_inst, NOP);
    chk(imem_addr == 32'd16, "R5 beq target", imem_addr, 16);
    chk(ex_pc == 32'd4, "R3 killed slot pc", ex_pc, 4);
    step(0, 0);
    chk(imem_addr == 32'd20, "R3 single bubble then sequential", imem_addr, 20);

    // signed less-than taken (R4)
    fill_nop();
    mem[0] = enc_b(3'd4, 13'd24);
    do_reset();
    step(0, 0);
    step(32'hFFFF_FFFF, 32'd1);
    chk(imem_addr == 32'd24, "R4 blt signed taken", imem_addr, 24);

    // unsigned less-than not taken for same operands (R4)
    fill_nop();
    mem[0] = enc_b(3'd6, 13'd24);
    do_reset();
    step(0, 0);
    step(32'hFFFF_FFFF, 32'd1);
    chk(imem_addr == 32'd8, "R4 bltu not taken", imem_addr, 8);

    // unused funct3 with equal operands (R4)
    fill_nop();
    mem[0] = enc_b(3'd2, 13'd24);
    do_reset();
    step(0, 0);
    step(7, 7);
    chk(imem_addr == 32'd8, "R4 funct3=2 never taken", imem_addr, 8);

    // jalr clears bit 0 (R7, R8)
    fill_nop();
    mem[0] = enc_jr(12'd5);
    do_reset();
    step(0, 0);
    chk(link_val == 32'd4, "R8 link for jalr", link_val, 4);
    step(32'h20, 0);
    chk(imem_addr == 32'h24, "R7 jalr target bit0 cleared", imem_addr, 32'h24);

    // backward jal (R6)
    fill_nop();
    mem[3] = enc_j(-21'sd12);
    do_reset();
    repeat (4) step(0, 0);
    step(0, 0);
    chk(imem_addr == 32'd0, "R6 jal backward target", imem_addr, 0);

    // non-control opcode with branch-like bits (R9)
    fill_nop();
    mem[0] = 32'hFFFF_F033;
    do_reset();
    step(0, 0);
    step(3, 3);
    chk(imem_addr == 32'd8, "R9 non-control sequential", imem_addr, 8);

    // random program, random operands
    for (int k = 0; k < 64; k++) begin
      case ($urandom % 10)
        0, 1, 2: mem[k] = enc_b(3'($urandom % 8), 13'(($urandom % 17) * 4 - 32));
        3:       mem[k] = enc_j(21'(($urandom % 17) * 4 - 32));
        4:       mem[k] = enc_jr(12'($urandom % 256));
        5:       mem[k] = {$urandom, 7'h33} & 32'hFFFF_FFB3;
        default: mem[k] = {$urandom, 7'h13} & 32'hFFFF_FF93 | 32'h13;
      endcase
    end
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      a = pick_val();
      b = ($urandom % 3 == 0) ? a : pick_val();
      step(a, b);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule